// File: doc/BRIEF.md
# Averaged Knob Reader with Deadband

This block turns a noisy stream of 10-bit readings from a control knob's converter into a steady 16-bit target delay word. Readings arrive one at a time, each marked by a one-cycle valid strobe. The block sums a fixed window of 256 valid readings. When the window closes, it scales the sum down to a 16-bit average and raises that average to a fixed floor if it falls short. It then compares the average with the target it currently holds.

The target moves only when the average has drifted at least a fixed deadband away from it. The new value is written with its two low bits cleared, so the target is always a multiple of four. A one-cycle flag marks each cycle in which the target takes a new value. Downstream logic reads the target as the desired delay. It can ignore knob jitter that stays inside the deadband.

Top module: `knob_avg_deadband`

## Requirements
- R1: Only cycles with `smp_vld_i` high add a reading to the window; the value on `smp_val_i` in other cycles has no effect on any later target.
- R2: A window holds exactly 256 valid readings summed without loss in an 18-bit sum; the window average is that sum shifted right by 2 (sum bits 17:2), a 16-bit value.
- R3: A window average below 0x0100 is replaced by 0x0100 before any comparison, so the target is never below 0x0100.
- R4: After reset the target is 0x0100 and the change flag is low.
- R5: When the absolute difference between the (floored) window average and the held target is 0x0040 or more, the target is updated. This holds whether the average is above or below the target.
- R6: When that difference is below 0x0040, the target keeps its value.
- R7: An updated target equals the floored window average with bits 1:0 forced to zero.
- R8: Each window starts from an empty sum and a zero reading count, whether or not the previous window updated the target.
- R9: `target_chg_o` is high for exactly the one cycle in which `target_o` first shows a new value, and low in every other cycle.
- R10: If the 256th valid reading of a window is sampled at clock edge k, the target shows its new value after edge k+1. The target never changes at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | One-cycle strobe marking a new converter reading |
| smp_val_i | input | 10 | Converter reading, unsigned |
| target_o | output | 16 | Registered target delay word |
| target_chg_o | output | 1 | One-cycle pulse when target_o takes a new value |

## Verification
The bench sets the window average to land exactly one count inside the deadband and exactly on its edge. It does this from above and from below. A design that used a strict comparison, or took the difference in only one direction, would miss an update or make an extra one. One window averages to a value with nonzero low bits, which catches a target that is not aligned to four. Another averages below the floor, which catches a missing clamp. Windows run back to back with different levels, and junk data sits on the bus between strobes. This exposes a sum that is not cleared between windows, or that counts cycles without a valid strobe, because either fault shifts the next average far past the deadband.

// File: rtl/knob_avg_pkg.sv
package knob_avg_pkg;

    localparam int unsigned SAMPLE_W_DEF = 10;
    localparam int unsigned WIN_LOG2_DEF = 8;
    localparam int unsigned DROP_DEF     = 2;
    localparam int unsigned ALIGN_DEF    = 2;

    // Result of the per-window evaluation
    typedef struct packed {
        logic under_floor;
        logic past_band;
    } judge_t;

    function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [31:0] lift_to(input logic [31:0] v, input logic [31:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/knob_avg_window.sv
module knob_avg_window
    import knob_avg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned WIN_LOG2 = WIN_LOG2_DEF,
    parameter int unsigned DROP     = DROP_DEF,
    localparam int unsigned ACC_W   = SAMPLE_W + WIN_LOG2,
    localparam int unsigned AVG_W   = ACC_W - DROP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] val_i,
    output logic                done_o,
    output logic [AVG_W-1:0]    avg_o
);

    logic [ACC_W-1:0]    acc_q;
    logic [WIN_LOG2-1:0] cnt_q;
    logic [ACC_W-1:0]    sum_nx;
    logic                last_w;

    assign sum_nx = acc_q + ACC_W'(val_i);
    assign last_w = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
            avg_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (vld_i) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_w) begin
                    acc_q  <= '0;
                    done_o <= 1'b1;
                    avg_o  <= sum_nx[ACC_W-1:DROP];
                end else begin
                    acc_q  <= sum_nx;
                end
            end
        end
    end

endmodule

// File: rtl/knob_target_filter.sv
module knob_target_filter
    import knob_avg_pkg::*;
#(
    parameter int unsigned          AVG_W = 16,
    parameter int unsigned          ALIGN = ALIGN_DEF,
    parameter logic [AVG_W-1:0]     FLOOR = 16'h0100,
    parameter logic [AVG_W-1:0]     BAND  = 16'h0040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic [AVG_W-1:0] avg_i,
    output logic [AVG_W-1:0] target_o,
    output logic             chg_o
);

    logic [AVG_W-1:0] lifted;
    logic [AVG_W-1:0] gap;
    logic [AVG_W-1:0] snapped;
    judge_t           jd;

    assign lifted         = AVG_W'(lift_to(32'(avg_i), 32'(FLOOR)));
    assign gap            = AVG_W'(abs_gap(32'(lifted), 32'(target_o)));
    assign jd.under_floor = (avg_i < FLOOR);
    assign jd.past_band   = (gap >= BAND);

    generate
        if (ALIGN == 0) begin : g_noalign
            assign snapped = lifted;
        end else begin : g_align
            assign snapped = {lifted[AVG_W-1:ALIGN], {ALIGN{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            target_o <= FLOOR;
            chg_o    <= 1'b0;
        end else begin
            chg_o <= 1'b0;
            if (done_i && jd.past_band) begin
                target_o <= snapped;
                chg_o    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/knob_avg_deadband.sv
module knob_avg_deadband
    import knob_avg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
    parameter int unsigned WIN_LOG2 = WIN_LOG2_DEF,
    parameter int unsigned DROP     = DROP_DEF,
    parameter int unsigned ALIGN    = ALIGN_DEF,
    localparam int unsigned AVG_W   = SAMPLE_W + WIN_LOG2 - DROP,
    parameter logic [AVG_W-1:0] FLOOR = 16'h0100,
    parameter logic [AVG_W-1:0] BAND  = 16'h0040
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_val_i,
    output logic [AVG_W-1:0]    target_o,
    output logic                target_chg_o
);

    logic             win_done;
    logic [AVG_W-1:0] win_avg;

    knob_avg_window #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LOG2 (WIN_LOG2),
        .DROP     (DROP)
    ) win_i (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (smp_vld_i),
        .val_i  (smp_val_i),
        .done_o (win_done),
        .avg_o  (win_avg)
    );

    knob_target_filter #(
        .AVG_W (AVG_W),
        .ALIGN (ALIGN),
        .FLOOR (FLOOR),
        .BAND  (BAND)
    ) flt_i (
        .clk      (clk),
        .rst      (rst),
        .done_i   (win_done),
        .avg_i    (win_avg),
        .target_o (target_o),
        .chg_o    (target_chg_o)
    );

endmodule

// File: rtl/knob_avg_chk.sv
module knob_avg_chk #(
    parameter int unsigned      AVG_W = 16,
    parameter int unsigned      ALIGN = 2,
    parameter logic [AVG_W-1:0] FLOOR = 16'h0100
) (
    input logic             clk,
    input logic             rst,
    input logic             win_done,
    input logic [AVG_W-1:0] target,
    input logic             chg
);

    // R7: target always a multiple of 2**ALIGN
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        (target % (1 << ALIGN)) == 0);

    // R3: target never below the floor
    a_r3_floor: assert property (@(posedge clk) disable iff (rst)
        target >= FLOOR);

    // R4: first cycle out of reset shows the floor and no flag
    a_r4_reset_val: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (target == FLOOR && !chg));

    // R10: without a closing window, target holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !win_done |=> $stable(target));

    // R9: any change of target is flagged
    a_r9_flag_on_change: assert property (@(posedge clk) disable iff (rst)
        (target != $past(target)) |-> chg);

    // R9: flag lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        chg |=> !chg);

endmodule

bind knob_avg_deadband knob_avg_chk #(
    .AVG_W (AVG_W),
    .ALIGN (ALIGN),
    .FLOOR (FLOOR)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .win_done (win_done),
    .target   (target_o),
    .chg      (target_chg_o)
);

// File: tb/knob_avg_deadband_tb_top.sv
module knob_avg_deadband_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld = 1'b0;
    logic [9:0]  val = '0;
    logic [15:0] target;
    logic        chg;

    int n_run  = 0;
    int n_fail = 0;
    int n_chg  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    knob_avg_deadband dut_i (
        .clk          (clk),
        .rst          (rst),
        .smp_vld_i    (vld),
        .smp_val_i    (val),
        .target_o     (target),
        .target_chg_o (chg)
    );

    // Behavioural reference
    int m_tgt, m_sum, m_cnt, m_pend;
    bit m_chg, m_pv;
    int m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_tgt = 256; m_chg = 0; m_sum = 0; m_cnt = 0; m_pv = 0;
            m_q.delete();
        end else begin
            m_chg = 0;
            if (m_pv) begin
                int a, d, nt;
                a = (m_pend < 256) ? 256 : m_pend;
                d = (a > m_tgt) ? a - m_tgt : m_tgt - a;
                if (d >= 64) begin
                    nt = a - (a % 4);
                    m_chg = (nt != m_tgt);
                    m_tgt = nt;
                end
                m_pv = 0;
            end
            if (vld) begin
                m_q.push_back(int'(val));
                m_sum += int'(val);
                m_cnt++;
                if (m_cnt == 256) begin
                    m_pend = m_sum / 4;
                    m_pv = 1;
                    m_sum = 0; m_cnt = 0;
                    m_q.delete();
                end
            end
        end
    end

    // Per-cycle comparison against the reference (R10 timing, R9 flag)
    always @(negedge clk) begin
        if (!rst && !ended) begin
            n_run++;
            if (int'(target) != m_tgt || chg != m_chg) begin
                n_fail++;
                $display("FAIL R10/R9 cycle compare: target=%h chg=%0d expected target=%h chg=%0d",
                         target, chg, m_tgt[15:0], m_chg);
            end
            if (chg) n_chg++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Send one window whose sum is 256*base + extra
    task automatic run_window(input int base, input int extra, input bit gaps);
        for (int i = 0; i < 256; i++) begin
            vld = 1'b1;
            val = 10'(base + extra / 256 + ((i < extra % 256) ? 1 : 0));
            @(negedge clk);
            if (gaps && (i % 3 == 0)) begin
                vld = 1'b0;
                val = 10'h3FF;
                @(negedge clk);
            end
        end
        vld = 1'b0;
        val = 10'h2AA;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 reset target", int'(target), 16'h0100);
        check("R4 reset flag", int'(chg), 0);

        run_window(0, 0, 1);                  // avg 0, junk between strobes
        check("R1 gaps ignored / R3 floor", int'(target), 16'h0100);

        run_window(1023, 0, 1);               // avg 0xFFC0
        check("R2 full-scale average", int'(target), 16'hFFC0);

        run_window(1000, 0, 0);               // avg 0xFA00, needs empty sum
        check("R8 window restarts empty", int'(target), 16'hFA00);

        run_window(1000, 252, 0);             // avg 0xFA3F, gap 0x3F above
        check("R6 one inside band, above", int'(target), 16'hFA00);

        run_window(1000, 268, 0);             // avg 0xFA43, update with low bits
        check("R7 aligned update", int'(target), 16'hFA40);

        run_window(1000, 0, 0);               // avg 0xFA00, gap exactly 0x40 below
        check("R5 band edge, below", int'(target), 16'hFA00);

        run_window(999, 4, 1);                // avg 0xF9C1, gap 0x3F below
        check("R6 one inside band, below", int'(target), 16'hFA00);

        run_window(3, 0, 0);                  // avg 0xC0 -> floor
        check("R3 floor applied", int'(target), 16'h0100);

        run_window(4, 252, 0);                // avg 0x013F, gap 0x3F
        check("R6 near floor", int'(target), 16'h0100);

        run_window(5, 0, 0);                  // avg 0x0140, gap exactly 0x40 above
        check("R5 band edge, above", int'(target), 16'h0140);

        check("R9 change pulse count", n_chg, 6);

        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule